// File: doc/BRIEF.md
# Power Domain Transaction Drain Unit

This block sits on a request/response crossing into a power domain that may be switched off. It keeps a running count of transactions that have been accepted into the domain but not yet answered. When a power-down is under way it closes the request path, lets responses keep flowing, and acknowledges the disconnect only once the count has fallen to zero. Only then may the supply be removed.

A small sequencer stands in for the system power controller. A one-cycle software command `pdown_cmd` starts a power-down. The sequencer moves from IDLE to REQ_DISCONNECT, raising the disconnect request. It then moves unconditionally to WAIT_ACK and holds there until the drain side acknowledges. On the acknowledge it moves to POWER_OFF, where the supply enable is low. A `pup_cmd` pulse in POWER_OFF moves it to POWER_ON_RESTORE, which drops the disconnect request and restores the supply. It returns to IDLE once the acknowledge has cleared. The current state is visible on `state_code`, encoded as IDLE=0, REQ_DISCONNECT=1, WAIT_ACK=2, POWER_OFF=3 and POWER_ON_RESTORE=4.

Top module: `pwr_drain_top`

## Requirements
- R1: A request handshake (`init_req_valid` and `init_req_ready` both high at a rising edge) raises `outstanding` by one at that edge. No handshake takes place while `tgt_req_ready` is low.
- R2: A response handshake (`rsp_valid` and `rsp_ready` both high at an edge) lowers `outstanding` by one.
- R3: A request handshake and a response handshake at the same edge leave `outstanding` unchanged.
- R4: While `disc_req` is high, `init_req_ready` and `tgt_req_valid` are both low. Responses are still counted during that time.
- R5: `disc_ack` goes high one cycle after a cycle in which `disc_req` is high and `outstanding` is zero. It is never high while `outstanding` is nonzero.
- R6: When `disc_req` goes low, `init_req_ready` follows `tgt_req_ready` again in that same cycle, and `disc_ack` falls one cycle later.
- R7: A request at the count limit `MAX_OUT`, or a response at a count of zero, leaves `outstanding` unchanged and sets the sticky `count_err`. Only reset clears `count_err`.
- R8: `pdown_cmd` in IDLE moves the state to REQ_DISCONNECT (code 1) at the next edge. One edge later the state is WAIT_ACK (code 2). `disc_req` is high in states 1, 2 and 3.
- R9: WAIT_ACK moves to POWER_OFF (code 3) at the first edge that sees `disc_ack` high. `supply_en` is low only in POWER_OFF.
- R10: `pup_cmd` in POWER_OFF moves the state to POWER_ON_RESTORE (code 4). That state moves to IDLE (code 0) at the first edge that sees `disc_ack` low.
- R11: `pdown_cmd` outside IDLE and `pup_cmd` outside POWER_OFF have no effect on the state.
- R12: After reset, `outstanding` is 0, the state is IDLE, `supply_en` is 1, and `disc_ack` and `count_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pdown_cmd | input | 1 | Software power-down command pulse |
| pup_cmd | input | 1 | Software power-up command pulse |
| init_req_valid | input | 1 | Request valid from the initiator side |
| init_req_ready | output | 1 | Gated request ready toward the initiator |
| tgt_req_valid | output | 1 | Gated request valid into the domain |
| tgt_req_ready | input | 1 | Request ready from inside the domain |
| rsp_valid | input | 1 | Response valid leaving the domain |
| rsp_ready | input | 1 | Response ready from the initiator |
| disc_req | output | 1 | Disconnect request from the sequencer |
| disc_ack | output | 1 | Drain complete acknowledge |
| supply_en | output | 1 | Domain supply enable |
| state_code | output | 3 | Current sequencer state code |
| outstanding | output | CNT_W | Transactions in flight |
| count_err | output | 1 | Sticky overflow or underflow flag |

## Verification
The bench builds the block with `MAX_OUT` set to 3, so `outstanding` is two bits wide. At that size, three requests fill the counter and a fourth exercises the overflow path within a few cycles. A second reset in the middle of the run gives a clean zero count for the underflow check. The power-down is started with two requests still in flight, so the drain through WAIT_ACK and the acknowledge timing are both observed.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_REQ_DISC     = 3'd1,
        ST_WAIT_ACK     = 3'd2,
        ST_POWER_OFF    = 3'd3,
        ST_PWR_RESTORE  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/pd_txn_counter.sv
module pd_txn_counter #(
    parameter int MAX_OUT = 15,
    localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero,
    output logic             err
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_OUT);

    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             ovf, unf;

    always_comb begin
        ovf = inc && !dec && (cnt_q == LIMIT);
        unf = dec && !inc && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (ovf || unf)
                err_q <= 1'b1;
            else if (inc && !dec)
                cnt_q <= cnt_q + 1'b1;
            else if (dec && !inc)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);
    assign err  = err_q;

    // R1
    p_cnt_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R2
    p_cnt_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R3
    p_cnt_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt_q));
    // R7
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/pd_gate.sv
module pd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic disc_req,
    input  logic cnt_zero,
    input  logic init_req_valid,
    input  logic tgt_req_ready,
    output logic init_req_ready,
    output logic tgt_req_valid,
    output logic req_fire,
    output logic disc_ack
);
    logic ack_q;

    always_comb begin
        init_req_ready = tgt_req_ready && !disc_req;
        tgt_req_valid  = init_req_valid && !disc_req;
        req_fire       = init_req_valid && init_req_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else
            ack_q <= disc_req && cnt_zero;
    end

    assign disc_ack = ack_q;

    // R5
    p_ack_only_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> cnt_zero);
    // R6
    p_ack_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disc_req) |=> !ack_q);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdown_cmd,
    input  logic       pup_cmd,
    input  logic       disc_ack,
    output logic       disc_req,
    output logic       supply_en,
    output logic [2:0] state_code
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (pdown_cmd) state_d = ST_REQ_DISC;
            ST_REQ_DISC:    state_d = ST_WAIT_ACK;
            ST_WAIT_ACK:    if (disc_ack) state_d = ST_POWER_OFF;
            ST_POWER_OFF:   if (pup_cmd) state_d = ST_PWR_RESTORE;
            ST_PWR_RESTORE: if (!disc_ack) state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        disc_req  = 1'b0;
        supply_en = 1'b1;
        unique case (state_q)
            ST_IDLE:        ;
            ST_REQ_DISC:    disc_req = 1'b1;
            ST_WAIT_ACK:    disc_req = 1'b1;
            ST_POWER_OFF: begin
                disc_req  = 1'b1;
                supply_en = 1'b0;
            end
            ST_PWR_RESTORE: ;
            default:        ;
        endcase
    end

    assign state_code = state_q;

    // R9
    p_off_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> $past(disc_ack));
    // R8
    p_req_then_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ_DISC) |=> (state_q == ST_WAIT_ACK));
    // R11
    p_legal_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_IDLE, ST_REQ_DISC, ST_WAIT_ACK, ST_POWER_OFF, ST_PWR_RESTORE});
endmodule

// File: rtl/pwr_drain_top.sv
module pwr_drain_top #(
    parameter int MAX_OUT = 15,
    localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdown_cmd,
    input  logic             pup_cmd,
    input  logic             init_req_valid,
    output logic             init_req_ready,
    output logic             tgt_req_valid,
    input  logic             tgt_req_ready,
    input  logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             disc_req,
    output logic             disc_ack,
    output logic             supply_en,
    output logic [2:0]       state_code,
    output logic [CNT_W-1:0] outstanding,
    output logic             count_err
);
    logic req_fire;
    logic rsp_fire;
    logic cnt_zero;

    assign rsp_fire = rsp_valid && rsp_ready;

    pd_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pdown_cmd  (pdown_cmd),
        .pup_cmd    (pup_cmd),
        .disc_ack   (disc_ack),
        .disc_req   (disc_req),
        .supply_en  (supply_en),
        .state_code (state_code)
    );

    pd_gate u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .disc_req       (disc_req),
        .cnt_zero       (cnt_zero),
        .init_req_valid (init_req_valid),
        .tgt_req_ready  (tgt_req_ready),
        .init_req_ready (init_req_ready),
        .tgt_req_valid  (tgt_req_valid),
        .req_fire       (req_fire),
        .disc_ack       (disc_ack)
    );

    pd_txn_counter #(.MAX_OUT(MAX_OUT)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (req_fire),
        .dec  (rsp_fire),
        .cnt  (outstanding),
        .zero (cnt_zero),
        .err  (count_err)
    );

    // R4: while drained, the count can only fall
    p_drain_no_growth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_req && $past(disc_req)) |-> (outstanding <= $past(outstanding)));
    // R4
    p_closed_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_req && init_req_valid) |=> ($past(outstanding) >= outstanding) || count_err);
endmodule

// File: tb/pwr_drain_top_test.sv
module pwr_drain_top_test;

    localparam int MAXO = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdown_cmd = 1'b0, pup_cmd = 1'b0;
    logic       init_req_valid = 1'b0, tgt_req_ready = 1'b1;
    logic       rsp_valid = 1'b0, rsp_ready = 1'b0;
    logic       init_req_ready, tgt_req_valid, disc_req, disc_ack, supply_en, count_err;
    logic [2:0] state_code;
    logic [1:0] outstanding;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct packed {
        logic [1:0] cnt;
        logic [2:0] st;
        logic       rdy;
        logic       tv;
        logic       ack;
        logic       sup;
        logic       err;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pwr_drain_top #(.MAX_OUT(MAXO)) uut (
        .clk(clk), .rst_n(rst_n), .pdown_cmd(pdown_cmd), .pup_cmd(pup_cmd),
        .init_req_valid(init_req_valid), .init_req_ready(init_req_ready),
        .tgt_req_valid(tgt_req_valid), .tgt_req_ready(tgt_req_ready),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .disc_req(disc_req),
        .disc_ack(disc_ack), .supply_en(supply_en), .state_code(state_code),
        .outstanding(outstanding), .count_err(count_err)
    );

    task automatic compare(input exp_t e, input string tag);
        n_checks++;
        if ({outstanding, state_code, init_req_ready, tgt_req_valid, disc_ack, supply_en, count_err} !== e) begin
            n_fail++;
            $display("FAIL %s: got cnt=%0d st=%0d rdy=%b tv=%b ack=%b sup=%b err=%b, expected cnt=%0d st=%0d rdy=%b tv=%b ack=%b sup=%b err=%b",
                tag, outstanding, state_code, init_req_ready, tgt_req_valid, disc_ack, supply_en, count_err,
                e.cnt, e.st, e.rdy, e.tv, e.ack, e.sup, e.err);
        end
    endtask

    // Monitor: pops one expectation per cycle, just after the edge it describes
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(e, t);
        end
    end

    // Driver: applies inputs at the falling edge and queues the state after the next rising edge
    task automatic step(input logic iv, input logic trd, input logic rsp, input logic pd, input logic pu,
                        input logic [1:0] cnt, input logic [2:0] st, input logic rdy, input logic tv,
                        input logic ack, input logic sup, input logic err, input string tag);
        exp_t e;
        @(negedge clk);
        init_req_valid = iv;
        tgt_req_ready  = trd;
        rsp_valid      = rsp;
        rsp_ready      = rsp;
        pdown_cmd      = pd;
        pup_cmd        = pu;
        e = '{cnt: cnt, st: st, rdy: rdy, tv: tv, ack: ack, sup: sup, err: err};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare('{cnt: 2'd0, st: 3'd0, rdy: 1'b1, tv: 1'b0, ack: 1'b0, sup: 1'b1, err: 1'b0}, "R12 reset");
        //    iv trd rsp pd pu  cnt st rdy tv ack sup err
        step(1, 1, 0, 0, 0, 2'd1, 3'd0, 1, 1, 0, 1, 0, "R1 first request");
        step(1, 1, 0, 0, 0, 2'd2, 3'd0, 1, 1, 0, 1, 0, "R1 second request");
        step(1, 1, 1, 0, 0, 2'd2, 3'd0, 1, 1, 0, 1, 0, "R3 request and response");
        step(0, 1, 1, 0, 0, 2'd1, 3'd0, 1, 0, 0, 1, 0, "R2 response");
        step(1, 0, 0, 0, 0, 2'd1, 3'd0, 0, 1, 0, 1, 0, "R1 target not ready");
        step(1, 1, 0, 1, 0, 2'd2, 3'd1, 0, 0, 0, 1, 0, "R8 power-down command");
        step(1, 1, 0, 0, 0, 2'd2, 3'd2, 0, 0, 0, 1, 0, "R4 request blocked");
        step(1, 1, 1, 0, 0, 2'd1, 3'd2, 0, 0, 0, 1, 0, "R4 response drains");
        step(0, 1, 1, 0, 0, 2'd0, 3'd2, 0, 0, 0, 1, 0, "R5 no ack before empty");
        step(0, 1, 0, 0, 0, 2'd0, 3'd2, 0, 0, 1, 1, 0, "R5 ack after empty");
        step(0, 1, 0, 0, 0, 2'd0, 3'd3, 0, 0, 1, 0, 0, "R9 supply off");
        step(0, 1, 0, 1, 0, 2'd0, 3'd3, 0, 0, 1, 0, 0, "R11 pdown ignored");
        step(0, 1, 0, 0, 1, 2'd0, 3'd4, 1, 0, 1, 1, 0, "R6 path reopens");
        step(0, 1, 0, 0, 0, 2'd0, 3'd4, 1, 0, 0, 1, 0, "R6 ack clears");
        step(0, 1, 0, 0, 0, 2'd0, 3'd0, 1, 0, 0, 1, 0, "R10 back to idle");
        step(0, 1, 0, 0, 1, 2'd0, 3'd0, 1, 0, 0, 1, 0, "R11 pup ignored");
        step(1, 1, 0, 0, 0, 2'd1, 3'd0, 1, 1, 0, 1, 0, "R1 fill one");
        step(1, 1, 0, 0, 0, 2'd2, 3'd0, 1, 1, 0, 1, 0, "R1 fill two");
        step(1, 1, 0, 0, 0, 2'd3, 3'd0, 1, 1, 0, 1, 0, "R1 fill limit");
        step(1, 1, 0, 0, 0, 2'd3, 3'd0, 1, 1, 0, 1, 1, "R7 overflow");
        step(0, 1, 1, 0, 0, 2'd2, 3'd0, 1, 0, 0, 1, 1, "R7 error sticky");
        step(0, 1, 0, 0, 0, 2'd2, 3'd0, 1, 0, 0, 1, 1, "R7 error holds");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        init_req_valid = 1'b0;
        rsp_valid = 1'b0;
        rsp_ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare('{cnt: 2'd0, st: 3'd0, rdy: 1'b1, tv: 1'b0, ack: 1'b0, sup: 1'b1, err: 1'b0}, "R12 second reset");
        step(0, 1, 1, 0, 0, 2'd0, 3'd0, 1, 0, 0, 1, 1, "R7 underflow");
        step(0, 1, 0, 0, 0, 2'd0, 3'd0, 1, 0, 0, 1, 1, "R7 underflow sticky");
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end
endmodule